// File: doc/BRIEF.md
# External Memory Bank Select Controller

This block drives the top address bit of a shared external SRAM that sits on the multiplexed bus of an 8051-class microcontroller. One chip holds both program and data: its upper bank holds code and its lower bank holds data. The bank bit is not decoded from the address bus. Instead it is worked out once per bus cycle from delayed copies of the address-latch strobe and from the program-fetch strobe.

Every bus cycle begins on the code bank. When the address-latch pulse has passed through a two-stage delay, the bank bit takes the inverse of the active-low fetch strobe. A pending fetch therefore stays on code, and a cycle with no fetch falls to the data bank. Data read and write strobes hold the bit at the data bank. A boot control pins the bit to the code bank, so a loader can use ordinary data writes to copy a program image into code space. Clearing that control returns the block to automatic selection.

In the intended system map, code RAM covers 0x12000 to 0x1FFFF and needs bank bit 1. Data RAM covers 0x02000 to 0x0F6FF and needs bank bit 0.

Top module: `membank_sel`

## Requirements
- R1: `bankSel` = 1 selects the code bank and `bankSel` = 0 selects the data bank. The output matches a half-cycle reference model on every clock edge.
- R2: While `rst` is high at a clock edge, both delay stages clear and the bank register is set to 1. The output reads 1 in the first cycle after reset is released.
- R3: `aleIn` is captured on the falling edge of `clk` into a first stage. While that stage is 1, `bankSel` is 1 with no wait for a rising edge, and the bank register is set to 1.
- R4: The first stage is copied into a second stage on the rising edge. On the rising edge after the second stage is seen to fall, the bank register loads the inverse of `psenN`. An address-latch pulse with no fetch and no data strobe therefore leaves `bankSel` at 0.
- R5: In a fetch cycle (`psenN` low after the address-latch pulse), `bankSel` stays 1 from the latch pulse to the end of the fetch. This also holds for back-to-back fetches and for a fetch that follows a data access.
- R6: While `rdN` or `wrN` is low and `bootForce` is 0, `bankSel` is 0 for the whole strobe, including a data access right after a fetch.
- R7: While `bootForce` is 1, `bankSel` is 1 whatever the bus does.
- R8: After `bootForce` returns to 0, the next data access reads 0 and the next fetch reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; both edges are used |
| rst | input | 1 | Synchronous reset, active high |
| aleIn | input | 1 | Address-latch strobe from the controller |
| psenN | input | 1 | Program fetch strobe, active low |
| rdN | input | 1 | Data read strobe, active low |
| wrN | input | 1 | Data write strobe, active low |
| bootForce | input | 1 | Holds the code bank while the loader runs |
| bankSel | output | 1 | Top address bit of the shared SRAM |

## Verification
The bench drives a fetch that follows a data access. A design that set the bank only at the decision edge would briefly put that fetch on the data bank, between the end of the latch pulse and the decision. It also drives a read right after a fetch. A design that waited for the registered decision would leave the first part of that read on the code bank. Boot-mode data writes must stay on code. The first data access after boot is left must drop to 0, or the loader's writes and the program's variables would land in the wrong half of the SRAM. An idle latch pulse with no strobe shows whether the fetch strobe is sampled with the correct polarity and at the correct edge.

// File: rtl/membank_sel_pkg.sv
package membank_sel_pkg;

  // strobes from the control half to the datapath half
  typedef struct packed {
    logic aleForce;    // first ALE stage is high: hold code bank
    logic aleFall;     // second ALE stage has just dropped: decide bank
    logic dataStrobe;  // a MOVX read or write strobe is active
  } bankCtl_t;

  localparam logic CODE_BANK = 1'b1;
  localparam logic DATA_BANK = 1'b0;

endpackage

// File: rtl/membank_sel_ctrl.sv
module membank_sel_ctrl
  import membank_sel_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     aleIn,
  input  logic     rdN,
  input  logic     wrN,
  output bankCtl_t strobes
);

  logic aleHalf;   // captured on the falling edge
  logic aleFull;   // re-captured on the rising edge
  logic aleFullQ;  // previous value of aleFull, for edge detection

  always_ff @(negedge clk) begin
    if (rst) aleHalf <= 1'b0;
    else     aleHalf <= aleIn;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      aleFull  <= 1'b0;
      aleFullQ <= 1'b0;
    end else begin
      aleFull  <= aleHalf;
      aleFullQ <= aleFull;
    end
  end

  always_comb begin
    strobes.aleForce   = aleHalf;
    strobes.aleFall    = aleFullQ & ~aleFull;
    strobes.dataStrobe = ~rdN | ~wrN;
  end

endmodule

// File: rtl/membank_sel_dp.sv
module membank_sel_dp
  import membank_sel_pkg::*;
#(
  parameter logic RESET_BANK = CODE_BANK
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     psenN,
  input  logic     bootForce,
  input  bankCtl_t strobes,
  output logic     bankSel
);

  logic bankReg;

  // priority: reset, new bus cycle, data strobe, per-cycle decision
  always_ff @(posedge clk) begin
    if (rst)                     bankReg <= RESET_BANK;
    else if (strobes.aleForce)   bankReg <= CODE_BANK;
    else if (strobes.dataStrobe) bankReg <= DATA_BANK;
    else if (strobes.aleFall)    bankReg <= ~psenN;
  end

  always_comb begin
    if (bootForce || strobes.aleForce) bankSel = CODE_BANK;
    else if (strobes.dataStrobe)       bankSel = DATA_BANK;
    else                               bankSel = bankReg;
  end

endmodule

// File: rtl/membank_sel.sv
module membank_sel
  import membank_sel_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic aleIn,
  input  logic psenN,
  input  logic rdN,
  input  logic wrN,
  input  logic bootForce,
  output logic bankSel
);

  bankCtl_t strb;

  membank_sel_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .aleIn   (aleIn),
    .rdN     (rdN),
    .wrN     (wrN),
    .strobes (strb)
  );

  membank_sel_dp #(.RESET_BANK(CODE_BANK)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .psenN     (psenN),
    .bootForce (bootForce),
    .strobes   (strb),
    .bankSel   (bankSel)
  );

endmodule

// File: rtl/membank_sel_chk.sv
module membank_sel_chk (
  input logic clk,
  input logic rst,
  input logic psenN,
  input logic rdN,
  input logic wrN,
  input logic bootForce,
  input logic aleForce,
  input logic aleFall,
  input logic bankSel
);

  AST_RESET_CODE: assert property (@(posedge clk)
    $fell(rst) && rdN && wrN |-> bankSel);                                  // R2

  AST_ALE_FORCE: assert property (@(posedge clk) disable iff (rst)
    aleForce |-> bankSel);                                                  // R3

  AST_DECIDE_BANK: assert property (@(posedge clk) disable iff (rst)
    aleFall && rdN && wrN && !aleForce |=>
      (bootForce || aleForce || !rdN || !wrN || bankSel == !$past(psenN))); // R4

  AST_DATA_LOW: assert property (@(posedge clk) disable iff (rst)
    (!rdN || !wrN) && !bootForce && !aleForce |-> !bankSel);                // R6

  AST_BOOT_HOLD: assert property (@(posedge clk) disable iff (rst)
    bootForce |-> bankSel);                                                 // R7

endmodule

bind membank_sel membank_sel_chk chk (
  .clk       (clk),
  .rst       (rst),
  .psenN     (psenN),
  .rdN       (rdN),
  .wrN       (wrN),
  .bootForce (bootForce),
  .aleForce  (strb.aleForce),
  .aleFall   (strb.aleFall),
  .bankSel   (bankSel)
);

// File: tb/membank_sel_test.sv
module membank_sel_test;

  localparam int CLK_PERIOD = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic aleIn = 1'b0, psenN = 1'b1, rdN = 1'b1, wrN = 1'b1, bootForce = 1'b0;
  logic bankSel;

  int vectors = 0, miscompares = 0;
  bit cmpOn = 0, done = 0;

  membank_sel uut (
    .clk(clk), .rst(rst), .aleIn(aleIn), .psenN(psenN),
    .rdN(rdN), .wrN(wrN), .bootForce(bootForce), .bankSel(bankSel)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference: half-cycle ALE history and the decided bank
  int aleHist[$];   // ALE values captured at falling edges, newest at back
  bit mFirst = 0;   // latest falling-edge sample of ALE
  bit mPrev1 = 0, mPrev2 = 0;  // rising-edge views, one and two edges old
  bit mBank = 1;

  always @(negedge clk) begin
    mFirst = rst ? 1'b0 : aleIn;
    aleHist.push_back(mFirst);
    if (aleHist.size() > 4) void'(aleHist.pop_front());
  end

  always @(posedge clk) begin
    bit fallSeen;
    fallSeen = mPrev2 && !mPrev1;
    if (rst)                 mBank = 1;
    else if (mFirst)         mBank = 1;
    else if (!rdN || !wrN)   mBank = 0;
    else if (fallSeen)       mBank = !psenN;
    mPrev2 = rst ? 1'b0 : mPrev1;
    mPrev1 = rst ? 1'b0 : mFirst;
  end

  function automatic bit expected();
    if (bootForce || mFirst) return 1;
    if (!rdN || !wrN)        return 0;
    return mBank;
  endfunction

  task automatic report(string req, logic got, logic exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s t=%0t bankSel=%b expected=%b", req, $time, got, exp);
    end
  endtask

  // R1: model comparison on both clock phases
  always @(posedge clk) begin #5; if (cmpOn) report("R1", bankSel, expected()); end
  always @(negedge clk) begin #5; if (cmpOn) report("R1", bankSel, expected()); end

  task automatic tick(); @(posedge clk); #2; endtask

  task automatic fetch();
    tick(); aleIn = 1;
    #13 report("R3", bankSel, 1'b1);
    tick(); aleIn = 0; psenN = 0;
    #3 report("R5", bankSel, 1'b1);
    tick(); #3 report("R5", bankSel, 1'b1);
    tick(); #3 report("R5", bankSel, 1'b1);
    psenN = 1;
  endtask

  task automatic movx(bit isWrite, logic exp, string req);
    tick(); aleIn = 1;
    tick(); aleIn = 0;
    tick(); if (isWrite) wrN = 0; else rdN = 0;
    #3 report(req, bankSel, exp);
    tick(); #3 report(req, bankSel, exp);
    tick(); #3 report(req, bankSel, exp);
    rdN = 1; wrN = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst = 0;
    #3 report("R2", bankSel, 1'b1);
    cmpOn = 1;
    tick(); #3 report("R2", bankSel, 1'b1);

    fetch();                 // R5 first fetch
    fetch();                 // R5 back-to-back
    movx(0, 1'b0, "R6");     // read right after fetch
    fetch();                 // R5 fetch after data access
    movx(1, 1'b0, "R6");     // write
    movx(0, 1'b0, "R6");     // data after data

    // R4: latch pulse with no strobe falls to the data bank
    tick(); aleIn = 1;
    tick(); aleIn = 0;
    repeat (4) tick();
    #3 report("R4", bankSel, 1'b0);

    // R7: boot holds code bank through data writes and reads
    bootForce = 1;
    movx(1, 1'b1, "R7");
    movx(0, 1'b1, "R7");
    tick(); #3 report("R7", bankSel, 1'b1);
    bootForce = 0;

    // R8: automatic selection resumes
    movx(1, 1'b0, "R8");
    fetch();
    tick(); #3 report("R8", bankSel, 1'b1);

    // R2: reset mid-stream after data access
    movx(0, 1'b0, "R6");
    rst = 1;
    repeat (2) tick();
    rst = 0;
    #3 report("R2", bankSel, 1'b1);
    fetch();

    repeat (3) tick();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule